// File: doc/BRIEF.md
# Dual-Clock Elastic Sample Buffer with Pointer Realignment

This block sits between a source clock domain that delivers paired I/Q samples and a converter clock domain that consumes them. Each write stores one I sample and one Q sample as a single entry in a small ring of storage. The read side takes entries out in the order they were written. Each side has its own pointer. The distance between the two pointers is the buffer occupancy, and it sets the data latency. It stays constant while the two rates match and drifts when they differ.

At power-up the pointer distance is arbitrary, so the block can realign the write pointer in two ways. A relative realignment places the write pointer a programmed number of entries ahead of the read pointer. An absolute realignment loads the programmed number straight into the write pointer, whatever the read pointer holds. A realignment can start from a software request or from a frame strobe on the source side. A software request always realigns relative. A frame strobe realigns absolute only when the alignment-mode input selects buffer mode. The nominal setting is an offset of half the depth.

Each realignment raises a one-cycle done pulse on the source side. The converter side reports the live occupancy.

Top module: `efifo_realign`

## Requirements
- R1: Entries leave the read port in write order. The I sample occupies `rd_i` and the Q sample occupies `rd_q`. `rd_valid` is high in the cycle after each read strobe, and it qualifies that cycle's data.
- R2: A software request always realigns relative, including when `align_mode` selects buffer mode. Once the pointers have crossed domains, `rd_depth` equals `phase_ofs`.
- R3: `sw_pending` rises in the converter cycle after `sw_req` is sampled high. It clears by itself once the realignment it asked for has completed.
- R4: A frame realignment is relative when `align_mode` is 0 (off), 1 (rate) or 3 (reserved). After it, `rd_depth` equals `phase_ofs`.
- R5: With `align_mode` = 2 (buffer mode), a frame realignment loads `phase_ofs` into the write pointer. `rd_depth` then equals (`phase_ofs` − reads since reset) mod DEPTH.
- R6: A frame realignment fires only after `frame` has been high on FRAME_LEN consecutive source edges. A shorter pulse leaves the occupancy and `realign_done` untouched.
- R7: A frame held high for longer than FRAME_LEN edges causes exactly one realignment.
- R8: `realign_done` is high for one source cycle directly after each pointer reload. It is high for no other cycle.
- R9: `rd_depth` = (write pointer − read pointer) mod DEPTH. Each write raises it by one and each read lowers it by one.
- R10: After reset, `rd_depth`, `rd_valid`, `realign_done` and `sw_pending` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Source (sample input) clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, source domain |
| wr_en | input | 1 | Store one I/Q entry at the write pointer |
| wr_i | input | SAMPLE_W | I sample to store |
| wr_q | input | SAMPLE_W | Q sample to store |
| frame | input | 1 | Frame strobe, source domain |
| align_mode | input | 2 | 0 off, 1 rate, 2 buffer mode, 3 reserved |
| phase_ofs | input | log2(DEPTH) | Offset (relative) or pointer value (absolute), quasi-static |
| realign_done | output | 1 | One-cycle pulse after a pointer reload |
| rd_clk | input | 1 | Converter clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, converter domain |
| rd_en | input | 1 | Take one entry at the read pointer |
| rd_i | output | SAMPLE_W | I sample read out |
| rd_q | output | SAMPLE_W | Q sample read out |
| rd_valid | output | 1 | Read data valid |
| rd_depth | output | log2(DEPTH) | Current occupancy |
| sw_req | input | 1 | Software realignment request, converter domain |
| sw_pending | output | 1 | Software request not yet completed |

## Verification
The bench builds the block with its default parameters: a depth of eight, 16-bit samples, a four-edge frame qualification and two-stage synchronizers. The three-bit pointers wrap several times over the run. As a result, relative and absolute reloads land on pointer values that give different occupancies, and the test can tell them apart. The four-edge frame length makes it cheap to drive a pulse one edge short and a pulse three times too long. The unrelated 10 and 14 time-unit clocks exercise the Gray-coded pointer crossings in both directions.

// File: rtl/efifo_pkg.sv
package efifo_pkg;

   // Alignment-mode encoding on the align_mode input
   typedef enum logic [1:0] {
      ALIGN_OFF  = 2'd0,
      ALIGN_RATE = 2'd1,
      ALIGN_BUF  = 2'd2,
      ALIGN_RSVD = 2'd3
   } align_mode_e;

   // Frame-started reloads are absolute only in buffer mode
   function automatic logic frame_is_absolute(input align_mode_e m);
      return (m == ALIGN_BUF);
   endfunction

endpackage

// File: rtl/efifo_sync.sv
module efifo_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("efifo_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("efifo_sync: W must be positive");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/efifo_ptr_cdc.sv
module efifo_ptr_cdc #(
   parameter int PTR_W  = 3,
   parameter int STAGES = 2
) (
   input  logic             src_clk,
   input  logic             src_rst_n,
   input  logic [PTR_W-1:0] src_bin,
   input  logic             dst_clk,
   input  logic             dst_rst_n,
   output logic [PTR_W-1:0] dst_bin
);

   if (PTR_W < 1) begin : g_bad_ptr
      $error("efifo_ptr_cdc: PTR_W must be positive");
   end

   logic [PTR_W-1:0] gray_src;
   logic [PTR_W-1:0] gray_dst;

   // Gray register in the launching domain, so only one bit moves per step
   always_ff @(posedge src_clk or negedge src_rst_n) begin
      if (!src_rst_n) gray_src <= '0;
      else            gray_src <= src_bin ^ (src_bin >> 1);
   end

   efifo_sync #(.W(PTR_W), .STAGES(STAGES)) i_gsync (
      .clk  (dst_clk),
      .rst_n(dst_rst_n),
      .d    (gray_src),
      .q    (gray_dst)
   );

   // Each binary bit is the parity of the Gray bits at and above it
   always_comb begin
      for (int k = 0; k < PTR_W; k++) begin
         dst_bin[k] = ^(gray_dst >> k);
      end
   end

endmodule

// File: rtl/efifo_frame_det.sv
module efifo_frame_det #(
   parameter int FRAME_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame,
   output logic fire
);

   if (FRAME_LEN < 1) begin : g_bad_len
      $error("efifo_frame_det: FRAME_LEN must be at least 1");
   end

   localparam int CNT_W = $clog2(FRAME_LEN + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);
   localparam logic [CNT_W-1:0] SAT  = CNT_W'(FRAME_LEN);

   // Number of consecutive earlier edges with the strobe high, saturating
   logic [CNT_W-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             run_cnt <= '0;
      else if (!frame)        run_cnt <= '0;
      else if (run_cnt != SAT) run_cnt <= run_cnt + 1'b1;
   end

   // Fires once, on the edge that completes the qualifying run
   assign fire = frame && (run_cnt == LAST);

endmodule

// File: rtl/efifo_wr_ctrl.sv
module efifo_wr_ctrl #(
   parameter int PTR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             frame_fire,
   input  logic             frame_abs,
   input  logic             sw_req_tog,
   input  logic [PTR_W-1:0] ofs,
   input  logic [PTR_W-1:0] rptr_w,
   output logic [PTR_W-1:0] wptr,
   output logic             sw_ack_tog,
   output logic             load,
   output logic             abs_q,
   output logic             done
);

   logic             sw_want;
   logic             load_sw;
   logic             use_abs;
   logic [PTR_W-1:0] target;

   // A toggle mismatch means a software request still waits to be served
   assign sw_want = sw_req_tog ^ sw_ack_tog;
   // The frame wins a tie; the software request then waits one cycle more
   assign load_sw = sw_want && !frame_fire;
   assign load    = frame_fire || load_sw;
   assign use_abs = frame_fire && frame_abs;
   assign target  = use_abs ? ofs : PTR_W'(rptr_w + ofs);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr       <= '0;
         sw_ack_tog <= 1'b0;
         done       <= 1'b0;
         abs_q      <= 1'b0;
      end else begin
         done <= load;
         if (load) begin
            wptr  <= target;
            abs_q <= use_abs;
         end else if (wr_en) begin
            wptr  <= wptr + 1'b1;
         end
         if (load_sw) sw_ack_tog <= ~sw_ack_tog;
      end
   end

endmodule

// File: rtl/efifo_rd_ctrl.sv
module efifo_rd_ctrl #(
   parameter int PTR_W  = 3,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [PTR_W-1:0]  wptr_r,
   input  logic              sw_req,
   input  logic              sw_ack_s,
   output logic [PTR_W-1:0]  rptr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [PTR_W-1:0]  depth,
   output logic              sw_req_tog,
   output logic              sw_pending
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr     <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            rd_data <= mem_rdata;
            rptr    <= rptr + 1'b1;
         end
      end
   end

   // Software request handshake: toggle out, acknowledge toggle back
   assign sw_pending = sw_req_tog ^ sw_ack_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     sw_req_tog <= 1'b0;
      else if (sw_req && !sw_pending) sw_req_tog <= ~sw_req_tog;
   end

   assign depth = PTR_W'(wptr_r - rptr);

endmodule

// File: rtl/efifo_realign.sv
module efifo_realign #(
   parameter int SAMPLE_W    = 16,
   parameter int DEPTH       = 8,
   parameter int FRAME_LEN   = 4,
   parameter int SYNC_STAGES = 2,
   localparam int PTR_W      = $clog2(DEPTH),
   localparam int DATA_W     = 2 * SAMPLE_W
) (
   input  logic                wr_clk,
   input  logic                wr_rst_n,
   input  logic                wr_en,
   input  logic [SAMPLE_W-1:0] wr_i,
   input  logic [SAMPLE_W-1:0] wr_q,
   input  logic                frame,
   input  logic [1:0]          align_mode,
   input  logic [PTR_W-1:0]    phase_ofs,
   output logic                realign_done,
   input  logic                rd_clk,
   input  logic                rd_rst_n,
   input  logic                rd_en,
   output logic [SAMPLE_W-1:0] rd_i,
   output logic [SAMPLE_W-1:0] rd_q,
   output logic                rd_valid,
   output logic [PTR_W-1:0]    rd_depth,
   input  logic                sw_req,
   output logic                sw_pending
);
   import efifo_pkg::*;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("efifo_realign: DEPTH must be a power of two, at least 2");
   end
   if (SAMPLE_W < 1) begin : g_bad_sample
      $error("efifo_realign: SAMPLE_W must be positive");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wptr, rptr, rptr_w, wptr_r;
   logic              frame_fire, frame_abs;
   logic              sw_req_tog, sw_req_tog_w, sw_ack_tog, sw_ack_s;
   logic              load, abs_q, done;
   logic [DATA_W-1:0] rd_data;
   align_mode_e       mode;

   assign mode      = align_mode_e'(align_mode);
   assign frame_abs = frame_is_absolute(mode);

   // ---------------- source domain ----------------
   efifo_frame_det #(.FRAME_LEN(FRAME_LEN)) i_fdet (
      .clk  (wr_clk),
      .rst_n(wr_rst_n),
      .frame(frame),
      .fire (frame_fire)
   );

   efifo_sync #(.W(1), .STAGES(SYNC_STAGES)) i_req_sync (
      .clk  (wr_clk),
      .rst_n(wr_rst_n),
      .d    (sw_req_tog),
      .q    (sw_req_tog_w)
   );

   efifo_wr_ctrl #(.PTR_W(PTR_W)) i_wctl (
      .clk       (wr_clk),
      .rst_n     (wr_rst_n),
      .wr_en     (wr_en),
      .frame_fire(frame_fire),
      .frame_abs (frame_abs),
      .sw_req_tog(sw_req_tog_w),
      .ofs       (phase_ofs),
      .rptr_w    (rptr_w),
      .wptr      (wptr),
      .sw_ack_tog(sw_ack_tog),
      .load      (load),
      .abs_q     (abs_q),
      .done      (done)
   );

   assign realign_done = done;

   // Storage: written in the source domain, read through a register in the converter domain
   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge wr_clk or negedge wr_rst_n) begin
         if (!wr_rst_n)                        mem[e] <= '0;
         else if (wr_en && wptr == PTR_W'(e))  mem[e] <= {wr_i, wr_q};
      end
   end

   // ---------------- pointer crossings ----------------
   efifo_ptr_cdc #(.PTR_W(PTR_W), .STAGES(SYNC_STAGES)) i_w2r (
      .src_clk  (wr_clk),
      .src_rst_n(wr_rst_n),
      .src_bin  (wptr),
      .dst_clk  (rd_clk),
      .dst_rst_n(rd_rst_n),
      .dst_bin  (wptr_r)
   );

   efifo_ptr_cdc #(.PTR_W(PTR_W), .STAGES(SYNC_STAGES)) i_r2w (
      .src_clk  (rd_clk),
      .src_rst_n(rd_rst_n),
      .src_bin  (rptr),
      .dst_clk  (wr_clk),
      .dst_rst_n(wr_rst_n),
      .dst_bin  (rptr_w)
   );

   // ---------------- converter domain ----------------
   efifo_sync #(.W(1), .STAGES(SYNC_STAGES)) i_ack_sync (
      .clk  (rd_clk),
      .rst_n(rd_rst_n),
      .d    (sw_ack_tog),
      .q    (sw_ack_s)
   );

   efifo_rd_ctrl #(.PTR_W(PTR_W), .DATA_W(DATA_W)) i_rctl (
      .clk       (rd_clk),
      .rst_n     (rd_rst_n),
      .rd_en     (rd_en),
      .mem_rdata (mem[rptr]),
      .wptr_r    (wptr_r),
      .sw_req    (sw_req),
      .sw_ack_s  (sw_ack_s),
      .rptr      (rptr),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid),
      .depth     (rd_depth),
      .sw_req_tog(sw_req_tog),
      .sw_pending(sw_pending)
   );

   assign rd_i = rd_data[DATA_W-1:SAMPLE_W];
   assign rd_q = rd_data[SAMPLE_W-1:0];

endmodule

// File: rtl/efifo_realign_chk.sv
module efifo_realign_chk #(
   parameter int PTR_W = 3
) (
   input logic             wr_clk,
   input logic             wr_rst_n,
   input logic             rd_clk,
   input logic             rd_rst_n,
   input logic             wr_en,
   input logic             rd_en,
   input logic             load,
   input logic             done,
   input logic             abs_q,
   input logic [PTR_W-1:0] wptr,
   input logic [PTR_W-1:0] rptr,
   input logic [PTR_W-1:0] rptr_w,
   input logic [PTR_W-1:0] phase_ofs,
   input logic             sw_req,
   input logic             sw_pending
);

   logic [PTR_W-1:0] rel_target;
   logic [PTR_W-1:0] wptr_inc;
   logic [PTR_W-1:0] rptr_inc;

   assign rel_target = PTR_W'(rptr_w + phase_ofs);
   assign wptr_inc   = PTR_W'(wptr + 1'b1);
   assign rptr_inc   = PTR_W'(rptr + 1'b1);

   // R2
   rel_reload_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (done && !abs_q) |-> (wptr == $past(rel_target)));

   // R5
   abs_reload_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (done && abs_q) |-> (wptr == $past(phase_ofs)));

   // R9
   wptr_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (!load && wr_en) |=> (wptr == $past(wptr_inc)));

   // R9
   wptr_hold_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (!load && !wr_en) |=> $stable(wptr));

   // R9
   rptr_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      rd_en |=> (rptr == $past(rptr_inc)));

   // R3
   pend_rise_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      $rose(sw_pending) |-> $past(sw_req));

endmodule

bind efifo_realign efifo_realign_chk #(.PTR_W(PTR_W)) i_chk (
   .wr_clk    (wr_clk),
   .wr_rst_n  (wr_rst_n),
   .rd_clk    (rd_clk),
   .rd_rst_n  (rd_rst_n),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .load      (load),
   .done      (done),
   .abs_q     (abs_q),
   .wptr      (wptr),
   .rptr      (rptr),
   .rptr_w    (rptr_w),
   .phase_ofs (phase_ofs),
   .sw_req    (sw_req),
   .sw_pending(sw_pending)
);

// File: tb/test_efifo_realign.sv
module test_efifo_realign;

   localparam int CLK_PERIOD = 10;
   localparam int RD_PERIOD  = CLK_PERIOD * 7 / 5;
   localparam int SW         = 16;
   localparam int DEPTH      = 8;
   localparam int PW         = 3;
   localparam int FLEN       = 4;

   logic          wr_clk = 0, rd_clk = 0;
   logic          wr_rst_n = 0, rd_rst_n = 0;
   logic          wr_en = 0, rd_en = 0, frame = 0, sw_req = 0;
   logic [SW-1:0] wr_i = '0, wr_q = '0;
   logic [1:0]    align_mode = 2'd0;
   logic [PW-1:0] phase_ofs = '0;
   logic          realign_done, rd_valid, sw_pending;
   logic [SW-1:0] rd_i, rd_q;
   logic [PW-1:0] rd_depth;

   always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
   always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

   efifo_realign i_efifo_realign (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_i(wr_i), .wr_q(wr_q),
      .frame(frame), .align_mode(align_mode), .phase_ofs(phase_ofs),
      .realign_done(realign_done), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
      .rd_i(rd_i), .rd_q(rd_q), .rd_valid(rd_valid), .rd_depth(rd_depth),
      .sw_req(sw_req), .sw_pending(sw_pending)
   );

   int n_checks = 0, n_fail = 0;
   int rd_count = 0, mon_skip = 0;
   int done_cnt = 0, done_run = 0, done_max = 0;
   logic [2*SW-1:0] exp_q[$];
   logic [SW-1:0]   seed = 16'h1000;
   bit finished = 0;

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   // Monitor: pops the scoreboard as read data appears (R1)
   always @(negedge rd_clk) begin
      if (rd_rst_n && rd_valid) begin
         if (mon_skip > 0) mon_skip--;
         else if (exp_q.size() == 0) check("R1 unexpected read", 1, 0);
         else begin
            logic [2*SW-1:0] e;
            e = exp_q.pop_front();
            check("R1 rd_i", int'(rd_i), int'(e[2*SW-1:SW]));
            check("R1 rd_q", int'(rd_q), int'(e[SW-1:0]));
         end
      end
   end

   // Done-pulse observer (R8)
   always @(negedge wr_clk) begin
      if (realign_done) begin
         done_cnt++;
         done_run++;
         if (done_run > done_max) done_max = done_run;
      end else done_run = 0;
   end

   task automatic settle();
      repeat (10) @(negedge rd_clk);
      repeat (4) @(negedge wr_clk);
   endtask

   task automatic push_writes(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge wr_clk);
         wr_en = 1; wr_i = seed; wr_q = ~seed;
         exp_q.push_back({seed, ~seed});
         seed = seed + 16'h0101;
      end
      @(negedge wr_clk) wr_en = 0;
      settle();
   endtask

   task automatic pull_reads(input int n, input int skip);
      mon_skip = skip;
      for (int k = 0; k < n; k++) begin
         @(negedge rd_clk) rd_en = 1;
      end
      @(negedge rd_clk) rd_en = 0;
      rd_count += n;
      settle();
   endtask

   task automatic sw_realign(input int ofs, input string tag);
      int d0, w;
      d0 = done_cnt;
      phase_ofs = PW'(ofs);
      @(negedge rd_clk) sw_req = 1;
      @(negedge rd_clk) sw_req = 0;
      check({tag, " R3 pending set"}, int'(sw_pending), 1);
      w = 0;
      while (sw_pending && w < 60) begin
         @(negedge rd_clk);
         w++;
      end
      check({tag, " R3 pending cleared"}, int'(sw_pending), 0);
      settle();
      check({tag, " R8 one done pulse"}, done_cnt - d0, 1);
   endtask

   task automatic frame_strobe(input int mode, input int ofs, input int len);
      align_mode = 2'(mode);
      phase_ofs  = PW'(ofs);
      @(negedge wr_clk) frame = 1;
      repeat (len) @(negedge wr_clk);
      frame = 0;
      settle();
   endtask

   initial begin
      int d0;
      repeat (3) @(negedge rd_clk);
      wr_rst_n = 1; rd_rst_n = 1;
      @(negedge rd_clk);
      // R10 reset state
      check("R10 depth", int'(rd_depth), 0);
      check("R10 rd_valid", int'(rd_valid), 0);
      check("R10 realign_done", int'(realign_done), 0);
      check("R10 sw_pending", int'(sw_pending), 0);

      // R2: software relative realign, offset 0
      sw_realign(0, "ofs0");
      check("R2 depth ofs0", int'(rd_depth), 0);

      // R9 / R1: write five, read five in order
      push_writes(5);
      check("R9 depth after writes", int'(rd_depth), 5);
      pull_reads(5, 0);
      check("R9 depth after reads", int'(rd_depth), 0);

      // R2: offset 3 relative to read pointer 5
      sw_realign(3, "ofs3");
      check("R2 depth ofs3", int'(rd_depth), 3);
      pull_reads(3, 3);
      push_writes(2);
      pull_reads(2, 0);
      check("R9 depth drained", int'(rd_depth), 0);

      // R4: frame, mode off, relative
      d0 = done_cnt;
      frame_strobe(0, 5, FLEN);
      check("R4 mode off depth", int'(rd_depth), 5);
      check("R8 frame done", done_cnt - d0, 1);
      pull_reads(5, 5);

      // R4: frame, rate mode, relative
      frame_strobe(1, 2, FLEN);
      check("R4 rate mode depth", int'(rd_depth), 2);
      pull_reads(2, 2);

      // R5: frame, buffer mode, absolute
      frame_strobe(2, 6, FLEN);
      check("R5 absolute depth", int'(rd_depth), (6 - rd_count) & (DEPTH - 1));
      pull_reads((6 - rd_count) & (DEPTH - 1), (6 - rd_count) & (DEPTH - 1));
      check("R9 depth after abs drain", int'(rd_depth), 0);

      // R6: pulse one edge short
      d0 = done_cnt;
      frame_strobe(1, 4, FLEN - 1);
      check("R6 short frame no done", done_cnt - d0, 0);
      check("R6 short frame depth", int'(rd_depth), 0);

      // R7: long pulse, single reload
      d0 = done_cnt;
      frame_strobe(1, 1, 3 * FLEN);
      check("R7 long frame one reload", done_cnt - d0, 1);
      check("R7 long frame depth", int'(rd_depth), 1);
      pull_reads(1, 1);

      // R2: software request in buffer mode stays relative
      align_mode = 2'd2;
      sw_realign(3, "bufmode");
      check("R2 sw in buffer mode depth", int'(rd_depth), 3);
      pull_reads(3, 3);

      // R1: final ordered stream
      push_writes(4);
      pull_reads(4, 0);
      check("R1 scoreboard empty", exp_q.size(), 0);

      // R8: no pulse longer than one cycle
      check("R8 max done width", done_max, 1);
      report();
   end

   initial begin
      #(CLK_PERIOD * 150000);
      check("watchdog expired", 1, 0);
      report();
   end

endmodule